// File: doc/BRIEF.md
# Single-Digit Hex Word Scroller

This block presents a 16-bit program-counter value on one seven-segment digit. Only one digit exists, so the word is shown over time: the four hex nibbles appear one after another, most significant first. Then the digit goes dark for a short pause, and the cycle repeats. It is meant as a cheap debug readout. A designer can watch where a slow-clocked processor is executing without adding more display hardware.

At the end of every dark pause, the program counter is copied into a holding register. All four digits of that pass come from this one copy, so a counter that moves during the pass never shows mixed digits. Each digit is held for a fixed number of clock cycles, and the pause for a separate fixed number. Both counts are parameters. An opcode word is also accepted on the interface but plays no part in the display. A synchronous clear returns the block to the start of a pause.

Top module: `hexseq_display`

## Requirements
- R1: While `rst_ni` is low, `seg_o` is all zeros. After release, a full pause of `GAP_CYCLES` clock cycles comes before the first digit.
- R2: Within a pass, the nibbles appear in the order bits [15:12], [11:8], [7:4], [3:0]. Each nibble is shown for exactly `DIGIT_CYCLES` clock cycles.
- R3: After the last nibble of a pass, `seg_o` is all zeros for exactly `GAP_CYCLES` cycles. The next pass then begins.
- R4: `seg_o` is active high with bit order {g,f,e,d,c,b,a} (bit 0 = a). The glyph values are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71 (hex). Every glyph lights at least one segment.
- R5: A change on `pc_i` during a pass has no effect on that pass. The new value appears only from the next pass.
- R6: `opc_i` has no effect on `seg_o`.
- R7: When `clr_i` is high at a clock edge, the block enters the pause with its timer restarted. While `clr_i` stays high, the display stays blank.
- R8: The value shown in a pass is the `pc_i` present at the clock edge that ends the preceding pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear, active high |
| pc_i | input | 16 | Program counter to display |
| opc_i | input | 16 | Opcode word, not displayed |
| seg_o | output | 7 | Segment drives {g,f,e,d,c,b,a}, active high |

## Verification
A corrupt phase register shows at the ports on the very next cycle. It appears either as a lit glyph where a blank is due, or as the wrong nibble, and no later recovery hides it. A timer that is off by one moves every later phase boundary. The bench samples every cycle of whole passes, so the error shows at the first boundary after the fault. A holding register that loads at the wrong time becomes visible when the counter moves in mid-pass, within the same digit period. A clear or a glyph-table fault shows within one pass.

// File: rtl/hexseq_pkg.sv
package hexseq_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned SEG_W  = 7;

  // low two bits of a digit phase select the nibble
  typedef enum logic [2:0] {
    PH_D0  = 3'd0,
    PH_D1  = 3'd1,
    PH_D2  = 3'd2,
    PH_D3  = 3'd3,
    PH_GAP = 3'd4
  } phase_e;
endpackage

// File: rtl/hexseq_timer.sv
module hexseq_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || done_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R2 R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
endmodule

// File: rtl/hexseq_fsm.sv
module hexseq_fsm
  import hexseq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   done_i,
  output phase_e phase_o,
  output logic   load_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (clr_i) phase_d = PH_GAP;
    else if (done_i) begin
      unique case (phase_q)
        PH_GAP:  phase_d = PH_D3;
        PH_D3:   phase_d = PH_D2;
        PH_D2:   phase_d = PH_D1;
        PH_D1:   phase_d = PH_D0;
        default: phase_d = PH_GAP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_GAP;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
  assign load_o  = (phase_q == PH_GAP) && done_i && !clr_i;

  // R2
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !clr_i) |=> $stable(phase_q));
  // R2
  msn_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_D3 && done_i && !clr_i) |=> (phase_q == PH_D2));
  // R7
  clr_to_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (phase_q == PH_GAP));
endmodule

// File: rtl/hexseq_seg7.sv
module hexseq_seg7
  import hexseq_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  input  logic             blank_i,
  output logic [SEG_W-1:0] seg_o
);
  logic [SEG_W-1:0] glyph;

  // {g,f,e,d,c,b,a}
  always_comb begin
    unique case (nib_i)
      4'h0: glyph = 7'h3F;
      4'h1: glyph = 7'h06;
      4'h2: glyph = 7'h5B;
      4'h3: glyph = 7'h4F;
      4'h4: glyph = 7'h66;
      4'h5: glyph = 7'h6D;
      4'h6: glyph = 7'h7D;
      4'h7: glyph = 7'h07;
      4'h8: glyph = 7'h7F;
      4'h9: glyph = 7'h6F;
      4'hA: glyph = 7'h77;
      4'hB: glyph = 7'h7C;
      4'hC: glyph = 7'h39;
      4'hD: glyph = 7'h5E;
      4'hE: glyph = 7'h79;
      default: glyph = 7'h71;
    endcase
  end

  assign seg_o = blank_i ? '0 : glyph;
endmodule

// File: rtl/hexseq_display.sv
module hexseq_display
  import hexseq_pkg::*;
#(
  parameter int unsigned DIGIT_CYCLES = 32'd8388608,
  parameter int unsigned GAP_CYCLES   = 32'd4194304
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] opc_i,
  output logic [SEG_W-1:0]  seg_o
);
  localparam int unsigned CNT_MAX = (DIGIT_CYCLES > GAP_CYCLES) ? DIGIT_CYCLES : GAP_CYCLES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DIG_LAST = CNT_W'(DIGIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

  logic              unused_opc;
  logic              done, load;
  phase_e            phase;
  logic [CNT_W-1:0]  last;
  logic [WORD_W-1:0] hold_q;
  logic [NIB_W-1:0]  nib;

  assign unused_opc = ^opc_i;
  assign last       = (phase == PH_GAP) ? GAP_LAST : DIG_LAST;

  hexseq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .last_i (last),
    .done_o (done)
  );

  hexseq_fsm i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .done_i  (done),
    .phase_o (phase),
    .load_o  (load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (load) hold_q <= pc_i;
  end

  assign nib = hold_q[phase[1:0]*NIB_W +: NIB_W];

  hexseq_seg7 i_seg7 (
    .nib_i   (nib),
    .blank_i (phase == PH_GAP),
    .seg_o   (seg_o)
  );

  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(hold_q));
  // R3
  gap_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_GAP) |-> (seg_o == '0));
  // R4
  digit_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_GAP) |-> (seg_o != '0));
endmodule

// File: tb/test_hexseq_display.sv
`timescale 1ns/1ps
module test_hexseq_display;
  localparam int D = 5;
  localparam int G = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [15:0] opc_i = '0;
  logic [6:0]  seg_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hexseq_display #(.DIGIT_CYCLES(D), .GAP_CYCLES(G)) i_hexseq_display (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i),
    .pc_i(pc_i), .opc_i(opc_i), .seg_o(seg_o)
  );

  function automatic logic [6:0] glyph(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic check(input logic [6:0] exp, input string req);
    checks++;
    if (seg_o !== exp) begin
      errors++;
      $display("FAIL %s seg_o=%h expected %h at %0t", req, seg_o, exp, $time);
    end
  endtask

  // Called at a negedge with the block at pause start. Walks one full pass.
  task automatic run_pass(input logic [15:0] shown, input int change_at,
                          input logic [15:0] new_pc, input int abort_at,
                          input bit wiggle_opc, input string req);
    for (int idx = 0; idx < G + 4*D; idx++) begin
      #1;
      if (idx < G) check(7'h00, {req, " R3 gap"});
      else begin
        int d = 3 - (idx - G) / D;
        check(glyph(shown[d*4 +: 4]), {req, " R2 R4 digit"});
      end
      if (wiggle_opc) opc_i = opc_i * 16'd5 + 16'h3B1; // R6
      if (idx == change_at) pc_i = new_pc;
      if (idx == abort_at) begin
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk); #1;
      check(7'h00, "R1 in reset");
    end
    pc_i = 16'h0123;
    @(negedge clk);
    rst_ni = 1'b1;
    run_pass(16'h0123, -1, '0, -1, 1'b0, "R1 first pass");
  endtask

  task automatic t_glyphs();
    pc_i = 16'h4567;
    run_pass(16'h4567, -1, '0, -1, 1'b1, "R6 opc wiggle");
    pc_i = 16'h89AB;
    run_pass(16'h89AB, -1, '0, -1, 1'b0, "R4 glyphs");
  endtask

  task automatic t_midchange();
    pc_i = 16'hCDEF;
    run_pass(16'hCDEF, G + 2, 16'h2A5C, -1, 1'b0, "R5 mid change");
    run_pass(16'h2A5C, -1, '0, -1, 1'b0, "R5 next pass");
  endtask

  task automatic t_capture_edge();
    pc_i = 16'h1111;
    run_pass(16'hF00D, G - 1, 16'hF00D, -1, 1'b0, "R8 capture edge");
  endtask

  task automatic t_clear();
    pc_i = 16'h7E31;
    run_pass(16'h7E31, -1, '0, G + D + 1, 1'b0, "R7 before clear");
    run_pass(16'h7E31, -1, '0, -1, 1'b0, "R7 after clear");
    clr_i = 1'b1;
    repeat (G + D + 2) begin
      @(negedge clk); #1;
      check(7'h00, "R7 clear held");
    end
    @(negedge clk);
    clr_i = 1'b0;
    pc_i = 16'hB0D9;
    run_pass(16'hB0D9, -1, '0, -1, 1'b0, "R7 release");
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_glyphs();
    t_midchange();
    t_capture_edge();
    t_clear();
    finish_run();
  end
endmodule